// File: doc/BRIEF.md
# Event Wait Register with Wake-Up Message

This block is one memory-mapped register that lets a single remote requester wait for a hardware event without polling. The requester reads the register and supplies a return address with the read. The block never answers on the read port. It always answers with a message on a valid/ready output. The message carries a destination address and a signed 16-bit status word.

When the block cannot take the wait, it replies at once with status -1 and keeps the requester that is already waiting. When an event is already recorded, it replies at once with status 0. In every other case it records the return address, counts ticks, and sends a wake-up message with the elapsed tick count once the event arrives. A register write of zero withdraws an outstanding wait.

Top module: `event_wait_reg`

## Requirements
- R1: After a synchronous active-high reset, no message is offered (msgValid low), no waiter is held and no event is recorded.
- R2: A wait request while idle, with an event recorded or an event on the same cycle, produces a message to the requester's address with status 0 on the next cycle, and clears the recorded event.
- R3: An event while no wait is pending sets a sticky flag. Several such events collapse into one flag, so only the first later request gets status 0 and the next request starts a real wait.
- R4: An accepted wait stores the return address. The wake-up goes to that stored address, with status equal to the number of tick cycles from the cycle after acceptance up to and including the event cycle. The wake-up appears two cycles after the event cycle. A delayed result below 1 is reported as 1.
- R5: A tick and an event on the same cycle count the tick before the event is taken, so an event with a tick on the first waiting cycle reports 1.
- R6: The tick count saturates at 32767 (0x7FFF) and never wraps to zero or a negative value.
- R7: A wait request while another requester waits gets status -1 (0xFFFF) at its own address on the next cycle. The existing waiter, its address and its count are kept.
- R8: Writing 0 while a wait is pending frees the slot. No wake-up is sent for it, and a later event sets the flag.
- R9: A nonzero write is ignored, and a zero write while no wait is pending has no effect.
- R10: An offered message holds its address and status until msgReady is high. Wait requests that arrive while a message is held and not being taken are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rdEn | input | 1 | Wait request (register read) strobe |
| rdRetAddr | input | 16 | Return address supplied with the wait request |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 16 | Write data; 0 cancels a pending wait |
| eventIn | input | 1 | Hardware event pulse |
| tickIn | input | 1 | Timer tick enable, one count per high cycle |
| msgValid | output | 1 | Message offered |
| msgReady | input | 1 | Message taken when high with msgValid |
| msgAddr | output | 16 | Destination address of the message |
| msgStatus | output | 16 | Two's-complement status: -1 busy, 0 already set, n>0 ticks elapsed |

## Verification
The assertions assume that rdEn, wrEn, eventIn and tickIn are single-cycle strobes that are sampled only at clock edges. They assume that msgReady may stay low for any number of cycles. They also assume that no register write and no wait request ever arrive in the same cycle. The stimulus drives every input on the falling edge. It keeps writes and wait requests on separate cycles and holds msgReady low only inside the back-pressure scenario. A behavioural model sees the same inputs, so any other overlap of event, tick and request stays legal and is checked on every cycle.

// File: rtl/event_wait_pkg.sv
package event_wait_pkg;
  typedef struct packed {
    logic startWait;     // capture return address, clear count
    logic countTick;     // advance count by one (saturating)
    logic captureEvent;  // fold tick of event cycle into count, floor at 1
    logic sendBusy;      // load message: requester address, status -1
    logic sendFlag;      // load message: requester address, status 0
    logic sendWake;      // load message: stored address, stored count
  } ewr_strobe_t;
endpackage

// File: rtl/event_wait_ctrl.sv
module event_wait_ctrl #(
  parameter int STAT_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rdEn,
  input  logic                     wrEn,
  input  logic [STAT_W-1:0]        wrData,
  input  logic                     eventIn,
  input  logic                     tickIn,
  input  logic                     msgReady,
  output logic                     msgValid,
  output event_wait_pkg::ewr_strobe_t st
);
  logic waiting, fired, flag;
  logic waitNext, firedNext, flagNext;
  logic cancel, outFree, anySend;

  assign cancel  = wrEn && (wrData == '0) && waiting;
  assign outFree = !msgValid || msgReady;
  assign anySend = st.sendBusy || st.sendFlag || st.sendWake;

  always_comb begin
    st        = '0;
    waitNext  = waiting;
    firedNext = fired;
    flagNext  = flag;
    if (cancel) begin
      waitNext  = 1'b0;
      firedNext = 1'b0;
      if (eventIn) flagNext = 1'b1;
    end else if (waiting && fired) begin
      if (eventIn) flagNext = 1'b1;
      if (outFree) begin
        st.sendWake = 1'b1;
        waitNext    = 1'b0;
        firedNext   = 1'b0;
      end
    end else if (waiting) begin
      if (eventIn) begin
        st.captureEvent = 1'b1;
        firedNext       = 1'b1;
      end else if (tickIn) begin
        st.countTick = 1'b1;
      end
      if (rdEn && outFree) st.sendBusy = 1'b1;
    end else begin
      if (rdEn && outFree) begin
        if (flag || eventIn) begin
          st.sendFlag = 1'b1;
          flagNext    = 1'b0;
        end else begin
          st.startWait = 1'b1;
          waitNext     = 1'b1;
        end
      end else if (eventIn) begin
        flagNext = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      waiting  <= 1'b0;
      fired    <= 1'b0;
      flag     <= 1'b0;
      msgValid <= 1'b0;
    end else begin
      waiting <= waitNext;
      fired   <= firedNext;
      flag    <= flagNext;
      if (anySend)       msgValid <= 1'b1;
      else if (msgReady) msgValid <= 1'b0;
    end
  end

  // R7: a second requester never displaces the current waiter
  p_busy_keeps_waiter_r7: assert property (@(posedge clk) disable iff (rst)
    (waiting && !fired && rdEn && !wrEn) |=> waiting);

  // R8: a zero write frees a pending wait
  p_cancel_frees_r8: assert property (@(posedge clk) disable iff (rst)
    (waiting && wrEn && (wrData == '0)) |=> !waiting);

  // R9: writes while idle never create a waiter
  p_idle_write_inert_r9: assert property (@(posedge clk) disable iff (rst)
    (!waiting && wrEn && !rdEn) |=> !waiting);

  // R10: an untaken message stays offered
  p_msg_held_r10: assert property (@(posedge clk) disable iff (rst)
    (msgValid && !msgReady) |=> msgValid);

  // R10: no wait is accepted while the output is blocked
  p_no_accept_blocked_r10: assert property (@(posedge clk) disable iff (rst)
    (!waiting && msgValid && !msgReady) |=> !waiting);

  // R2: a recorded event is consumed by the immediate reply
  p_flag_consumed_r2: assert property (@(posedge clk) disable iff (rst)
    (!waiting && flag && rdEn && outFree) |=> (!flag && msgValid));
endmodule

// File: rtl/event_wait_dpath.sv
module event_wait_dpath #(
  parameter int ADDR_W = 16,
  parameter int STAT_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  event_wait_pkg::ewr_strobe_t st,
  input  logic                       tickIn,
  input  logic [ADDR_W-1:0]          rdRetAddr,
  input  logic                       msgValid,
  input  logic                       msgReady,
  output logic [ADDR_W-1:0]          msgAddr,
  output logic [STAT_W-1:0]          msgStatus
);
  localparam int CNT_W = STAT_W - 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0]  count;
  logic [ADDR_W-1:0] retAddr;
  logic [CNT_W:0]    sum;
  logic [CNT_W-1:0]  satSum, captured;

  assign sum      = {1'b0, count} + {{CNT_W{1'b0}}, tickIn};
  assign satSum   = sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
  assign captured = (satSum == '0) ? CNT_ONE : satSum;

  always_ff @(posedge clk) begin
    if (rst) begin
      count     <= '0;
      retAddr   <= '0;
      msgAddr   <= '0;
      msgStatus <= '0;
    end else begin
      if (st.startWait) begin
        count   <= '0;
        retAddr <= rdRetAddr;
      end else if (st.captureEvent) begin
        count <= captured;
      end else if (st.countTick) begin
        count <= satSum;
      end
      if (st.sendWake) begin
        msgAddr   <= retAddr;
        msgStatus <= {1'b0, count};
      end else if (st.sendBusy) begin
        msgAddr   <= rdRetAddr;
        msgStatus <= '1;
      end else if (st.sendFlag) begin
        msgAddr   <= rdRetAddr;
        msgStatus <= '0;
      end
    end
  end

  // R10: address and status frozen while the message waits for ready
  p_msg_stable_r10: assert property (@(posedge clk) disable iff (rst)
    (msgValid && !msgReady) |=> ($stable(msgAddr) && $stable(msgStatus)));

  // R4/R6: a wake-up never reports zero or a negative count
  p_wake_positive_r4: assert property (@(posedge clk) disable iff (rst)
    st.sendWake |=> (!msgStatus[STAT_W-1] && (msgStatus != '0)));
endmodule

// File: rtl/event_wait_reg.sv
module event_wait_reg #(
  parameter int ADDR_W = 16,
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdRetAddr,
  input  logic              wrEn,
  input  logic [STAT_W-1:0] wrData,
  input  logic              eventIn,
  input  logic              tickIn,
  output logic              msgValid,
  input  logic              msgReady,
  output logic [ADDR_W-1:0] msgAddr,
  output logic [STAT_W-1:0] msgStatus
);
  event_wait_pkg::ewr_strobe_t st;

  event_wait_ctrl #(.STAT_W(STAT_W)) u_ctrl (
    .clk(clk), .rst(rst), .rdEn(rdEn), .wrEn(wrEn), .wrData(wrData),
    .eventIn(eventIn), .tickIn(tickIn), .msgReady(msgReady),
    .msgValid(msgValid), .st(st)
  );

  event_wait_dpath #(.ADDR_W(ADDR_W), .STAT_W(STAT_W)) u_dpath (
    .clk(clk), .rst(rst), .st(st), .tickIn(tickIn), .rdRetAddr(rdRetAddr),
    .msgValid(msgValid), .msgReady(msgReady),
    .msgAddr(msgAddr), .msgStatus(msgStatus)
  );
endmodule

// File: tb/test_event_wait_reg.sv
module test_event_wait_reg;
  localparam int CLK_PERIOD = 10;
  localparam int MAXCNT = 32767;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rdEn = 1'b0, wrEn = 1'b0, eventIn = 1'b0, tickIn = 1'b0, msgReady = 1'b1;
  logic [15:0] rdRetAddr = '0, wrData = '0;
  logic msgValid;
  logic [15:0] msgAddr, msgStatus;

  int checks = 0, fails = 0, cycles = 0;
  string curTag = "R1";

  // behavioural model state
  bit mWait, mFired, mFlag, mValid;
  int mCnt;
  logic [15:0] mRet, mAddr, mStat;

  event_wait_reg i_event_wait_reg (
    .clk(clk), .rst(rst), .rdEn(rdEn), .rdRetAddr(rdRetAddr),
    .wrEn(wrEn), .wrData(wrData), .eventIn(eventIn), .tickIn(tickIn),
    .msgValid(msgValid), .msgReady(msgReady),
    .msgAddr(msgAddr), .msgStatus(msgStatus)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    bit free, load;
    logic [15:0] nAddr, nStat;
    cycles++;
    load = 0; nAddr = '0; nStat = '0;
    if (rst) begin
      mWait = 0; mFired = 0; mFlag = 0; mValid = 0; mCnt = 0;
      mRet = '0; mAddr = '0; mStat = '0;
    end else begin
      free = !mValid || msgReady;
      if (wrEn && wrData == 0 && mWait) begin
        mWait = 0; mFired = 0;
        if (eventIn) mFlag = 1;
      end else if (mWait && mFired) begin
        if (eventIn) mFlag = 1;
        if (free) begin load = 1; nAddr = mRet; nStat = 16'(mCnt); mWait = 0; mFired = 0; end
      end else if (mWait) begin
        if (eventIn) begin
          mFired = 1;
          mCnt = mCnt + (tickIn ? 1 : 0);
          if (mCnt > MAXCNT) mCnt = MAXCNT;
          if (mCnt < 1) mCnt = 1;
        end else if (tickIn) begin
          mCnt = (mCnt >= MAXCNT) ? MAXCNT : mCnt + 1;
        end
        if (rdEn && free) begin load = 1; nAddr = rdRetAddr; nStat = 16'hFFFF; end
      end else begin
        if (rdEn && free) begin
          if (mFlag || eventIn) begin load = 1; nAddr = rdRetAddr; nStat = 16'h0000; mFlag = 0; end
          else begin mWait = 1; mCnt = 0; mRet = rdRetAddr; end
        end else if (eventIn) mFlag = 1;
      end
      if (load) begin mValid = 1; mAddr = nAddr; mStat = nStat; end
      else if (msgReady) mValid = 0;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (msgValid !== mValid) begin
        fails++;
        $display("FAIL %s model: msgValid actual %0b expected %0b", curTag, msgValid, mValid);
      end else if (mValid && (msgAddr !== mAddr || msgStatus !== mStat)) begin
        fails++;
        $display("FAIL %s model: msg actual %h/%h expected %h/%h",
                 curTag, msgAddr, msgStatus, mAddr, mStat);
      end
    end
  end

  always @(negedge clk) begin
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic step(input bit r, input logic [15:0] a, input bit w,
                      input logic [15:0] d, input bit e, input bit t);
    rdEn = r; rdRetAddr = a; wrEn = w; wrData = d; eventIn = e; tickIn = t;
    @(negedge clk);
    rdEn = 0; wrEn = 0; eventIn = 0; tickIn = 0;
  endtask

  task automatic idle();
    step(0, '0, 0, '0, 0, 0);
  endtask

  task automatic expectMsg(input string tag, input bit v, input logic [15:0] a,
                           input logic [15:0] s);
    checks++;
    if (msgValid !== v || (v && (msgAddr !== a || msgStatus !== s))) begin
      fails++;
      $display("FAIL %s: actual v=%0b %h/%h expected v=%0b %h/%h",
               tag, msgValid, msgAddr, msgStatus, v, a, s);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    expectMsg("R1 reset", 0, '0, '0);
    idle();
    expectMsg("R1 idle after reset", 0, '0, '0);

    // R3 collapse of idle events, R2 immediate zero
    curTag = "R3";
    step(0, '0, 0, '0, 1, 0);
    step(0, '0, 0, '0, 1, 0);
    step(1, 16'h00A1, 0, '0, 0, 0);
    expectMsg("R2 flag reply", 1, 16'h00A1, 16'h0000);
    step(1, 16'h00A2, 0, '0, 0, 0);
    expectMsg("R3 second request waits", 0, '0, '0);
    // R4 delayed wake-up
    curTag = "R4";
    repeat (3) step(0, '0, 0, '0, 0, 1);
    step(0, '0, 0, '0, 1, 0);
    expectMsg("R4 fired not yet sent", 0, '0, '0);
    idle();
    expectMsg("R4 wake count 3", 1, 16'h00A2, 16'd3);
    idle();

    // R5 tick with event on first waiting cycle
    curTag = "R5";
    step(1, 16'h00A3, 0, '0, 0, 0);
    step(0, '0, 0, '0, 1, 1);
    idle();
    expectMsg("R5 tick counted first", 1, 16'h00A3, 16'd1);
    idle();
    curTag = "R4";
    step(1, 16'h00B3, 0, '0, 0, 0);
    step(0, '0, 0, '0, 1, 0);
    idle();
    expectMsg("R4 floor at 1", 1, 16'h00B3, 16'd1);
    idle();

    // R2 event on the same cycle as the request
    curTag = "R2";
    step(1, 16'h00C1, 0, '0, 1, 0);
    expectMsg("R2 same-cycle event", 1, 16'h00C1, 16'h0000);
    idle();

    // R7 busy reply
    curTag = "R7";
    step(1, 16'h00A4, 0, '0, 0, 0);
    step(0, '0, 0, '0, 0, 1);
    step(0, '0, 0, '0, 0, 1);
    step(1, 16'h00A5, 0, '0, 0, 0);
    expectMsg("R7 busy to newcomer", 1, 16'h00A5, 16'hFFFF);
    step(0, '0, 0, '0, 0, 1);
    step(0, '0, 0, '0, 1, 0);
    idle();
    expectMsg("R7 waiter kept", 1, 16'h00A4, 16'd3);
    idle();

    // R8 cancel
    curTag = "R8";
    step(1, 16'h00A6, 0, '0, 0, 0);
    step(0, '0, 0, '0, 0, 1);
    step(0, '0, 1, 16'h0000, 0, 0);
    step(0, '0, 0, '0, 1, 0);
    idle();
    expectMsg("R8 no wake after cancel", 0, '0, '0);
    step(1, 16'h00A7, 0, '0, 0, 0);
    expectMsg("R8 event after cancel sets flag", 1, 16'h00A7, 16'h0000);
    idle();

    // R9 ignored writes
    curTag = "R9";
    step(0, '0, 1, 16'h0000, 0, 0);
    step(1, 16'h00A8, 0, '0, 0, 0);
    expectMsg("R9 idle cancel inert", 0, '0, '0);
    step(0, '0, 1, 16'h0005, 0, 0);
    step(0, '0, 0, '0, 0, 1);
    step(0, '0, 0, '0, 1, 0);
    idle();
    expectMsg("R9 nonzero write ignored", 1, 16'h00A8, 16'd1);
    idle();

    // R10 back-pressure
    curTag = "R10";
    msgReady = 0;
    step(0, '0, 0, '0, 1, 0);
    step(1, 16'h00A9, 0, '0, 0, 0);
    expectMsg("R10 offered", 1, 16'h00A9, 16'h0000);
    step(1, 16'h00AA, 0, '0, 0, 0);
    expectMsg("R10 held", 1, 16'h00A9, 16'h0000);
    idle();
    expectMsg("R10 still held", 1, 16'h00A9, 16'h0000);
    msgReady = 1;
    idle();
    expectMsg("R10 taken", 0, '0, '0);
    step(0, '0, 0, '0, 1, 0);
    idle();
    expectMsg("R10 dropped request not waiting", 0, '0, '0);
    step(1, 16'h00AB, 0, '0, 0, 0);
    expectMsg("R10 flag from later event", 1, 16'h00AB, 16'h0000);
    idle();

    // R6 saturation
    curTag = "R6";
    step(1, 16'h00AC, 0, '0, 0, 0);
    repeat (MAXCNT + 100) step(0, '0, 0, '0, 0, 1);
    step(0, '0, 0, '0, 1, 1);
    idle();
    expectMsg("R6 saturated count", 1, 16'h00AC, 16'h7FFF);
    idle();

    // R1 reset clears a recorded event
    curTag = "R1";
    step(0, '0, 0, '0, 1, 0);
    rst = 1;
    idle();
    rst = 0;
    step(1, 16'h00AD, 0, '0, 0, 0);
    expectMsg("R1 reset cleared flag", 0, '0, '0);
    idle();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule